// File: doc/BRIEF.md
# Mixed-Depth Pixel Scanout Selector

This block forms the colour of each scanned pixel for a frame buffer that holds three planes. The first is an indexed plane with one byte per pixel. The second is a direct-colour plane with one 32-bit word per pixel. The third is a control plane, also one 32-bit word per pixel. The three planes lie back to back in one address space. The indexed plane starts at byte 0, the direct plane follows it, and the control plane follows the direct plane. Every plane uses a fixed line pitch of 1024 pixels, and the visible area is at most 1024 by 768.

The block has two independent paths.

- **Address generator.** A scan request carries x/y coordinates. One cycle later the generator returns the byte address of that pixel in each of the three planes.
- **Pixel selector.** It accepts the index byte, the direct word and the control word of one pixel in the same cycle. It issues a read on an external palette port at once. The direct colour is delayed to match the palette latency, and one registered multiplexer then chooses the result. A pixel takes its direct colour when the tag in its control word marks it as direct. In every other case it takes the palette entry for its index. A configuration input selects indexed-only depth, and that input forces the palette path for every pixel.

Top module: `mixed_depth_scanout`

## Requirements
- R1: When bits 31:24 of a pixel's control word equal 0x03 and indexed-only depth is off, `outRgb` equals bits 23:0 of that pixel's direct word, and `outDirect` is 1.
- R2: When bits 31:24 of the control word hold any value other than 0x03, `outRgb` equals the palette data returned for that pixel's index, and `outDirect` is 0. `palRdEn` and `palRdIdx` mirror `pixValid` and `pixIndex` in the same cycle.
- R3: Bits 31:24 of the direct word and bits 23:0 of the control word have no effect on `outRgb` or `outDirect`.
- R4: While `depthIndexedOnly` is 1 for a pixel, that pixel takes the palette colour with `outDirect` = 0, whatever its control word holds.
- R5: `outValid` rises exactly PAL_LAT+1 cycles after each accepted `pixValid`. Back-to-back pixels and pixels separated by gaps leave in input order, with no pixel lost or added.
- R6: One cycle after `addrReqValid`, `addrValid` is 1 and `idxAddr` equals y*1024 + x.
- R7: `dirAddr` equals 786432 + 4*(y*1024 + x).
- R8: `ctlAddr` equals 3932160 + 4*(y*1024 + x).
- R9: While reset is held, and right after it, `outValid`, `addrValid` and `outRgb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| depthIndexedOnly | input | 1 | 1 forces the palette path for every pixel |
| addrReqValid | input | 1 | Scan address request |
| scanX | input | 10 | Pixel column |
| scanY | input | 10 | Pixel line |
| addrValid | output | 1 | Plane addresses are valid |
| idxAddr | output | 23 | Byte address in the indexed plane |
| dirAddr | output | 23 | Byte address in the direct-colour plane |
| ctlAddr | output | 23 | Byte address in the control plane |
| pixValid | input | 1 | Pixel data present |
| pixIndex | input | 8 | Index byte |
| pixDirect | input | 32 | Direct-colour word (bits 23:0 are R, G, B) |
| pixCtrl | input | 32 | Control word (tag in bits 31:24) |
| palRdEn | output | 1 | Palette read request |
| palRdIdx | output | 8 | Palette entry to read |
| palRdData | input | 24 | Palette colour, PAL_LAT cycles after the request |
| outValid | output | 1 | Output colour valid |
| outRgb | output | 24 | Output colour |
| outDirect | output | 1 | 1 when the colour came from the direct plane |

## Verification
The bench runs four kinds of selector traffic.

- **Palette tags.** Tags next to 0x03 (0x00, 0x02, 0x04, 0x83, 0xFF) must all stay on the palette path. A comparison that tests only some of the tag bits fails here.
- **Direct pixels.** These carry non-zero junk in the ignored direct and control bits. A leak of the wrong byte into the output shows up here.
- **Indexed-only pixels.** These pixels carry the direct tag, so they show whether the depth override is honoured.
- **Mixed streams.** Back-to-back and gapped sequences alternate between the two paths. They show whether the direct delay line stays aligned with the palette return, and whether order and latency are kept.

Address requests at the four corners of the visible area, and at points in between, tell apart errors in line pitch, in byte scaling and in the plane bases.

// File: rtl/pixsel_pkg.sv
package pixsel_pkg;

  localparam logic [7:0] DIRECT_TAG = 8'h03;

  // Strobes from control to datapath at the output multiplexer stage
  typedef struct packed {
    logic loadOut;
    logic pickDirect;
  } selStrobe_t;

  function automatic logic tagIsDirect(input logic [31:0] ctrlWord);
    return ctrlWord[31:24] == DIRECT_TAG;
  endfunction

  function automatic logic [23:0] directRgb(input logic [31:0] dirWord);
    return dirWord[23:0];
  endfunction

endpackage

// File: rtl/scan_addr_gen.sv
module scan_addr_gen #(
  parameter int LINE_PIX  = 1024,
  parameter int MAX_LINES = 768,
  parameter int X_W       = 10,
  parameter int Y_W       = 10,
  parameter int ADDR_W    = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [X_W-1:0]    reqX,
  input  logic [Y_W-1:0]    reqY,
  output logic              addrValid,
  output logic [ADDR_W-1:0] idxAddr,
  output logic [ADDR_W-1:0] dirAddr,
  output logic [ADDR_W-1:0] ctlAddr
);

  localparam int PLANE_PIX = LINE_PIX * MAX_LINES;
  localparam int DIR_BASE  = PLANE_PIX;
  localparam int CTL_BASE  = PLANE_PIX * 5;
  localparam int WORD_SH   = 2;

  logic [ADDR_W-1:0] linPix;
  logic [ADDR_W-1:0] wordOff;

  always_comb begin
    linPix  = ADDR_W'(reqY) * ADDR_W'(LINE_PIX) + ADDR_W'(reqX);
    wordOff = linPix << WORD_SH;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      idxAddr   <= '0;
      dirAddr   <= '0;
      ctlAddr   <= '0;
    end else begin
      addrValid <= reqValid;
      if (reqValid) begin
        idxAddr <= linPix;
        dirAddr <= ADDR_W'(DIR_BASE) + wordOff;
        ctlAddr <= ADDR_W'(CTL_BASE) + wordOff;
      end
    end
  end

endmodule

// File: rtl/pixsel_ctrl.sv
module pixsel_ctrl
  import pixsel_pkg::*;
#(
  parameter int PAL_LAT = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pixValid,
  input  logic [31:0] pixCtrl,
  input  logic        depthIndexedOnly,
  output selStrobe_t  strobe
);

  logic [PAL_LAT-1:0] validPipe;
  logic [PAL_LAT-1:0] directPipe;
  logic               wantDirect;

  always_comb wantDirect = pixValid && tagIsDirect(pixCtrl) && !depthIndexedOnly;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe[0]  <= 1'b0;
      directPipe[0] <= 1'b0;
    end else begin
      validPipe[0]  <= pixValid;
      directPipe[0] <= wantDirect;
    end
  end

  for (genvar k = 1; k < PAL_LAT; k++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validPipe[k]  <= 1'b0;
        directPipe[k] <= 1'b0;
      end else begin
        validPipe[k]  <= validPipe[k-1];
        directPipe[k] <= directPipe[k-1];
      end
    end
  end

  always_comb begin
    strobe.loadOut    = validPipe[PAL_LAT-1];
    strobe.pickDirect = directPipe[PAL_LAT-1];
  end

endmodule

// File: rtl/pixsel_datapath.sv
module pixsel_datapath
  import pixsel_pkg::*;
#(
  parameter int PAL_LAT = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pixValid,
  input  logic [31:0] pixDirect,
  input  logic [23:0] palRdData,
  input  selStrobe_t  strobe,
  output logic        outValid,
  output logic [23:0] outRgb,
  output logic        outDirect
);

  logic [23:0] rgbPipe [PAL_LAT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rgbPipe[0] <= '0;
    end else if (pixValid) begin
      rgbPipe[0] <= directRgb(pixDirect);
    end
  end

  for (genvar k = 1; k < PAL_LAT; k++) begin : gDelay
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rgbPipe[k] <= '0;
      else       rgbPipe[k] <= rgbPipe[k-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outRgb    <= '0;
      outDirect <= 1'b0;
    end else begin
      outValid <= strobe.loadOut;
      if (strobe.loadOut) begin
        outRgb    <= strobe.pickDirect ? rgbPipe[PAL_LAT-1] : palRdData;
        outDirect <= strobe.pickDirect;
      end
    end
  end

endmodule

// File: rtl/mixed_depth_scanout.sv
module mixed_depth_scanout
  import pixsel_pkg::*;
#(
  parameter int LINE_PIX  = 1024,
  parameter int MAX_LINES = 768,
  parameter int PAL_LAT   = 1,
  parameter int X_W       = $clog2(LINE_PIX),
  parameter int Y_W       = $clog2(MAX_LINES),
  parameter int ADDR_W    = $clog2(LINE_PIX * MAX_LINES * 9)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              depthIndexedOnly,
  input  logic              addrReqValid,
  input  logic [X_W-1:0]    scanX,
  input  logic [Y_W-1:0]    scanY,
  output logic              addrValid,
  output logic [ADDR_W-1:0] idxAddr,
  output logic [ADDR_W-1:0] dirAddr,
  output logic [ADDR_W-1:0] ctlAddr,
  input  logic              pixValid,
  input  logic [7:0]        pixIndex,
  input  logic [31:0]       pixDirect,
  input  logic [31:0]       pixCtrl,
  output logic              palRdEn,
  output logic [7:0]        palRdIdx,
  input  logic [23:0]       palRdData,
  output logic              outValid,
  output logic [23:0]       outRgb,
  output logic              outDirect
);

  selStrobe_t selStrobe;

  always_comb begin
    palRdEn  = pixValid;
    palRdIdx = pixIndex;
  end

  scan_addr_gen #(
    .LINE_PIX(LINE_PIX), .MAX_LINES(MAX_LINES),
    .X_W(X_W), .Y_W(Y_W), .ADDR_W(ADDR_W)
  ) addrGen_i (
    .clk(clk), .rstN(rstN),
    .reqValid(addrReqValid), .reqX(scanX), .reqY(scanY),
    .addrValid(addrValid), .idxAddr(idxAddr),
    .dirAddr(dirAddr), .ctlAddr(ctlAddr)
  );

  pixsel_ctrl #(.PAL_LAT(PAL_LAT)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .pixValid(pixValid), .pixCtrl(pixCtrl),
    .depthIndexedOnly(depthIndexedOnly),
    .strobe(selStrobe)
  );

  pixsel_datapath #(.PAL_LAT(PAL_LAT)) data_i (
    .clk(clk), .rstN(rstN),
    .pixValid(pixValid), .pixDirect(pixDirect),
    .palRdData(palRdData), .strobe(selStrobe),
    .outValid(outValid), .outRgb(outRgb), .outDirect(outDirect)
  );

endmodule

// File: rtl/mixed_depth_scanout_chk.sv
module mixed_depth_scanout_chk #(
  parameter int PAL_LAT = 1,
  parameter int LINE_PIX = 1024,
  parameter int MAX_LINES = 768,
  parameter int ADDR_W  = 23
) (
  input logic              clk,
  input logic              rstN,
  input logic              pixValid,
  input logic              addrValid,
  input logic [ADDR_W-1:0] idxAddr,
  input logic [ADDR_W-1:0] dirAddr,
  input logic [ADDR_W-1:0] ctlAddr,
  input logic [23:0]       palRdData,
  input logic              outValid,
  input logic [23:0]       outRgb,
  input logic              outDirect
);

  localparam int PLANE_PIX = LINE_PIX * MAX_LINES;

  logic [PAL_LAT:0] seenValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenValid <= '0;
    else       seenValid <= {seenValid[PAL_LAT-1:0], pixValid};
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid == seenValid[PAL_LAT]);

  assert_direct_base_R7: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> dirAddr == ADDR_W'(PLANE_PIX) + (idxAddr << 2));

  assert_ctrl_base_R8: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> ctlAddr - dirAddr == ADDR_W'(PLANE_PIX * 4));

  assert_palette_path_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outDirect) |-> outRgb == $past(palRdData));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rstN |=> (!outValid && !addrValid));

endmodule

bind mixed_depth_scanout mixed_depth_scanout_chk #(
  .PAL_LAT(PAL_LAT), .LINE_PIX(LINE_PIX), .MAX_LINES(MAX_LINES), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rstN(rstN), .pixValid(pixValid),
  .addrValid(addrValid), .idxAddr(idxAddr), .dirAddr(dirAddr), .ctlAddr(ctlAddr),
  .palRdData(palRdData), .outValid(outValid), .outRgb(outRgb), .outDirect(outDirect)
);

// File: tb/mixed_depth_scanout_tb_top.sv
module mixed_depth_scanout_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PAL_LAT    = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        depthIndexedOnly = 1'b0;
  logic        addrReqValid = 1'b0;
  logic [9:0]  scanX = '0;
  logic [9:0]  scanY = '0;
  logic        addrValid;
  logic [22:0] idxAddr, dirAddr, ctlAddr;
  logic        pixValid = 1'b0;
  logic [7:0]  pixIndex = '0;
  logic [31:0] pixDirect = '0;
  logic [31:0] pixCtrl = '0;
  logic        palRdEn;
  logic [7:0]  palRdIdx;
  logic [23:0] palRdData = '0;
  logic        outValid;
  logic [23:0] outRgb;
  logic        outDirect;

  int nChecks = 0;
  int nFails  = 0;
  int cycCnt  = 0;

  logic [23:0] expRgbQ[$];
  logic        expDirQ[$];
  int          expCycQ[$];
  string       expReqQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycCnt <= cycCnt + 1;

  mixed_depth_scanout #(.PAL_LAT(PAL_LAT)) dut_i (
    .clk(clk), .rstN(rstN), .depthIndexedOnly(depthIndexedOnly),
    .addrReqValid(addrReqValid), .scanX(scanX), .scanY(scanY),
    .addrValid(addrValid), .idxAddr(idxAddr), .dirAddr(dirAddr), .ctlAddr(ctlAddr),
    .pixValid(pixValid), .pixIndex(pixIndex), .pixDirect(pixDirect), .pixCtrl(pixCtrl),
    .palRdEn(palRdEn), .palRdIdx(palRdIdx), .palRdData(palRdData),
    .outValid(outValid), .outRgb(outRgb), .outDirect(outDirect)
  );

  function automatic logic [23:0] palColour(input logic [7:0] i);
    return {i, i ^ 8'hFF, i + 8'h37};
  endfunction

  // Palette memory model with a latency of one cycle
  always @(posedge clk) if (palRdEn) palRdData <= palColour(palRdIdx);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Output monitor: order, value, path flag and latency (R1 R2 R5)
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expRgbQ.size() == 0) begin
        check("R5 unexpected outValid", 32'd1, 32'd0);
      end else begin
        string rq;
        rq = expReqQ.pop_front();
        check({rq, " colour"}, {8'd0, outRgb}, {8'd0, expRgbQ.pop_front()});
        check({rq, " path flag"}, {31'd0, outDirect}, {31'd0, expDirQ.pop_front()});
        check("R5 latency", cycCnt - expCycQ.pop_front(), PAL_LAT + 1);
      end
    end
  end

  task automatic sendPix(input string req, input logic [7:0] idx, input logic [31:0] dir,
                         input logic [31:0] ctl, input logic idxOnly);
    logic useDir;
    @(negedge clk);
    pixValid = 1'b1; pixIndex = idx; pixDirect = dir; pixCtrl = ctl;
    depthIndexedOnly = idxOnly;
    check("R2 palette request", {23'd0, palRdEn, palRdIdx}, {23'd0, 1'b1, idx});
    useDir = (ctl[31:24] == 8'h03) && !idxOnly;
    expRgbQ.push_back(useDir ? dir[23:0] : palColour(idx));
    expDirQ.push_back(useDir);
    expCycQ.push_back(cycCnt);
    expReqQ.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pixValid = 1'b0; depthIndexedOnly = 1'b0;
      pixDirect = 32'hDEAD_BEEF; pixCtrl = 32'h0300_0000;
    end
  endtask

  task automatic drain();
    idle(PAL_LAT + 4);
    check("R5 all pixels delivered", expRgbQ.size(), 0);
  endtask

  task automatic tReset();
    check("R9 outValid in reset", {31'd0, outValid}, 0);
    check("R9 addrValid in reset", {31'd0, addrValid}, 0);
    check("R9 outRgb in reset", {8'd0, outRgb}, 0);
  endtask

  task automatic tPaletteTags();
    sendPix("R2 tag 00", 8'h00, 32'h0011_2233, 32'h0000_0000, 1'b0);
    sendPix("R2 tag 02", 8'h01, 32'h0044_5566, 32'h0200_0000, 1'b0);
    sendPix("R2 tag 04", 8'h80, 32'h0077_8899, 32'h0400_0000, 1'b0);
    sendPix("R2 tag 83", 8'hFE, 32'h00AA_BBCC, 32'h8300_0000, 1'b0);
    sendPix("R2 tag FF", 8'hFF, 32'h00DD_EEFF, 32'hFF03_0303, 1'b0);
    drain();
  endtask

  task automatic tDirect();
    sendPix("R1 direct", 8'h10, 32'h0012_3456, 32'h0300_0000, 1'b0);
    sendPix("R3 junk top byte", 8'h20, 32'hFFAB_CDEF, 32'h03FF_FFFF, 1'b0);
    sendPix("R3 junk low ctrl", 8'h30, 32'h5AFF_FFFF, 32'h0312_3456, 1'b0);
    sendPix("R1 direct zero", 8'hFF, 32'hFF00_0000, 32'h0300_0001, 1'b0);
    drain();
  endtask

  task automatic tIndexedOnly();
    sendPix("R4 forced palette", 8'h42, 32'h00C0_FFEE, 32'h0300_0000, 1'b1);
    sendPix("R4 direct after mode off", 8'h43, 32'h00C0_FFEE, 32'h0300_0000, 1'b0);
    sendPix("R4 forced palette again", 8'h44, 32'h0012_1212, 32'h03AB_CDEF, 1'b1);
    drain();
  endtask

  task automatic tMixedStream();
    for (int i = 0; i < 16; i++) begin
      sendPix("R5 b2b mix", 8'(i * 13), {8'hA5, 8'(i), 8'(i * 3), 8'(255 - i)},
              (i % 2 == 0) ? 32'h0300_0000 : 32'h0100_0000, 1'b0);
    end
    for (int i = 0; i < 8; i++) begin
      sendPix("R5 gapped mix", 8'(200 + i), {8'h00, 8'(i * 7), 8'h5A, 8'(i)},
              (i % 3 == 0) ? 32'h0100_0000 : 32'h0300_0000, 1'b0);
      idle(i % 3 + 1);
    end
    drain();
  endtask

  task automatic tAddr(input int x, input int y);
    int lin;
    lin = y * 1024 + x;
    @(negedge clk);
    addrReqValid = 1'b1; scanX = 10'(x); scanY = 10'(y);
    @(negedge clk);
    addrReqValid = 1'b0;
    check("R6 addrValid", {31'd0, addrValid}, 1);
    check("R6 index address", {9'd0, idxAddr}, lin);
    check("R7 direct address", {9'd0, dirAddr}, 786432 + 4 * lin);
    check("R8 control address", {9'd0, ctlAddr}, 3932160 + 4 * lin);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tPaletteTags();
    tDirect();
    tIndexedOnly();
    tMixedStream();
    tAddr(0, 0);
    tAddr(1023, 767);
    tAddr(5, 1);
    tAddr(1023, 0);
    tAddr(0, 767);
    tAddr(517, 300);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule